// File: doc/BRIEF.md
# Per-Processor Interrupt Acknowledge Interface

This block is the processor-side end of an interrupt controller, with one copy for each processor. The distributor hands it one candidate, the best pending interrupt, as an ID and an 8-bit priority. The block checks that candidate against a software threshold, an enable bit and its own record of interrupts already in service. When all checks pass, it raises a registered request line to the processor.

Software talks to the block through four word-addressed registers. Reading the acknowledge register returns the candidate's ID and makes that ID active. In the same cycle the block sends a pulse to the distributor, which can then drop the ID's pending state if the interrupt is edge-triggered. Writing an ID to the completion register ends that ID's active state. When nothing is eligible, the acknowledge read returns the reserved ID 1023 and has no side effect.

Top module: `cif_top`

## Requirements
- R1: Bit 0 of the control register (word offset 0) turns signalling on. While this bit is 0, `irq_o` stays low and an acknowledge read returns 1023.
- R2: A candidate is signalled only if its priority is strictly less than the 8-bit threshold in the mask register (word offset 1). A priority equal to or greater than the threshold is never signalled.
- R3: Reading offset 0 returns the enable bit in bit 0. Reading offset 1 returns the threshold in bits 7:0. All other bits read as 0, and both registers reset to 0.
- R4: Reading the acknowledge register (word offset 2) while a candidate is eligible returns its ID in bits 9:0, with bits 31:10 equal to 0.
- R5: Reading the acknowledge register when no candidate is eligible returns 1023.
- R6: A non-spurious acknowledge read pulses `ack_valid_o` for exactly that cycle, with `ack_id_o` equal to the returned ID. A spurious read produces no pulse.
- R7: An acknowledged ID becomes active and is not signalled again until software writes that ID to the completion register (word offset 3, ID in bits 9:0).
- R8: A completion write naming an ID that is not active has no effect. In particular, an ID that is still active stays blocked.
- R9: `irq_o` is low in the cycle after an acknowledge read. It rises again, one cycle after the fact, only when a different eligible candidate is presented.
- R10: A candidate with an ID above 1020, or at or above `NUM_IDS`, is never signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cand_valid_i | input | 1 | Distributor presents a candidate |
| cand_id_i | input | 10 | Candidate interrupt ID |
| cand_prio_i | input | 8 | Candidate priority, lower value is more urgent |
| bus_en_i | input | 1 | Register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Word offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the read |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_valid_o | output | 1 | Acknowledge pulse to the distributor |
| ack_id_o | output | 10 | ID being acknowledged |

## Verification
The assertions assume that a register access lasts exactly one cycle. They also assume the distributor keeps the candidate stable during an acknowledge read, so the ID returned and the ID reported in the pulse come from the same sample. The stimulus changes candidate and register inputs only on the falling clock edge and holds each access for a single cycle. It never changes the candidate in the middle of an acknowledge read. IDs above the active-tracking range are used only to check that they are filtered out.

// File: rtl/cif_pkg.sv
// Package: shared constants and register offsets for the acknowledge interface.
// Assumes a 10-bit interrupt ID space, with 1023 reserved as the "nothing" code.
package cif_pkg;
    localparam int ID_W      = 10;
    localparam int PRIO_W    = 8;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 2;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;
    localparam logic [ID_W-1:0] MAX_REAL_ID = 10'd1020;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_MASK = 2'd1,
        REG_ACK  = 2'd2,
        REG_DONE = 2'd3
    } reg_off_e;
endpackage

// File: rtl/cif_regs.sv
// Module: holds the enable bit and the priority threshold, and serves their read-back.
// Assumes single-cycle accesses; the acknowledge and completion offsets are decoded elsewhere.
module cif_regs
    import cif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_mask,
    input  logic [DATA_W-1:0] wdata,
    output logic              en_q,
    output logic [PRIO_W-1:0] mask_q,
    output logic [DATA_W-1:0] ctrl_rd,
    output logic [DATA_W-1:0] mask_rd
);
    // Register updates for the enable and threshold fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mask_q <= '0;
        end else begin
            if (wr_ctrl) en_q   <= wdata[0];
            if (wr_mask) mask_q <= wdata[PRIO_W-1:0];
        end
    end

    // Read-back values with unused bits held at zero.
    always_comb begin
        ctrl_rd = {{(DATA_W-1){1'b0}}, en_q};
        mask_rd = {{(DATA_W-PRIO_W){1'b0}}, mask_q};
    end
endmodule

// File: rtl/cif_active.sv
// Module: one in-service bit per tracked ID, set on acknowledge and cleared on completion.
// Assumes callers never set an ID at or above NUM_IDS; padding bits stay zero.
module cif_active
    import cif_pkg::*;
#(
    parameter int NUM_IDS = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [ID_W-1:0] set_id,
    input  logic            clr_en,
    input  logic [ID_W-1:0] clr_id,
    input  logic [ID_W-1:0] look_id,
    output logic            look_hit
);
    localparam int IDX_W = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1;
    localparam int SLOTS = 1 << IDX_W;

    logic [SLOTS-1:0] active_q;

    // One flop per slot; slots past NUM_IDS are tied off.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < NUM_IDS) begin : g_live
            // Set wins over clear when both name the same slot in one cycle.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    active_q[g] <= 1'b0;
                else if (set_en && set_id == ID_W'(g))
                    active_q[g] <= 1'b1;
                else if (clr_en && clr_id == ID_W'(g))
                    active_q[g] <= 1'b0;
            end
        end else begin : g_pad
            assign active_q[g] = 1'b0;
        end
    end

    // Look up whether the presented ID is in service; out-of-range IDs read as free.
    always_comb begin
        if (look_id < ID_W'(NUM_IDS))
            look_hit = active_q[look_id[IDX_W-1:0]];
        else
            look_hit = 1'b0;
    end
endmodule

// File: rtl/cif_signal.sv
// Module: decides whether the candidate may be signalled and drives the registered request line.
// Assumes the candidate is stable for the cycle it is evaluated in.
module cif_signal
    import cif_pkg::*;
#(
    parameter int NUM_IDS = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [PRIO_W-1:0] mask,
    input  logic              cand_valid,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic              cand_busy,
    input  logic              ack_now,
    output logic              eligible,
    output logic              irq_q
);
    logic id_ok;

    // Eligibility: enabled, urgent enough, a real tracked ID, and not already in service.
    always_comb begin
        id_ok    = (cand_id <= MAX_REAL_ID) && (cand_id < ID_W'(NUM_IDS));
        eligible = en && cand_valid && id_ok && !cand_busy && (cand_prio < mask);
    end

    // Request line: registered, forced low in the cycle after an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= eligible && !ack_now;
    end
endmodule

// File: rtl/cif_top.sv
// Module: per-processor acknowledge interface; decodes the register bus and links the parts.
// Assumes one-cycle bus accesses with read data consumed in the same cycle.
module cif_top
    import cif_pkg::*;
#(
    parameter int NUM_IDS = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cand_valid_i,
    input  logic [9:0]  cand_id_i,
    input  logic [7:0]  cand_prio_i,
    input  logic        bus_en_i,
    input  logic        bus_we_i,
    input  logic [1:0]  bus_addr_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    output logic        irq_o,
    output logic        ack_valid_o,
    output logic [9:0]  ack_id_o
);
    logic              wr_ctrl, wr_mask, wr_done, rd_ack;
    logic              en_q, eligible, busy, ack_now;
    logic [PRIO_W-1:0] mask_q;
    logic [DATA_W-1:0] ctrl_rd, mask_rd;
    logic [ID_W-1:0]   ack_val;

    // Bus decode into per-register strobes.
    always_comb begin
        wr_ctrl = bus_en_i &&  bus_we_i && bus_addr_i == REG_CTRL;
        wr_mask = bus_en_i &&  bus_we_i && bus_addr_i == REG_MASK;
        wr_done = bus_en_i &&  bus_we_i && bus_addr_i == REG_DONE;
        rd_ack  = bus_en_i && !bus_we_i && bus_addr_i == REG_ACK;
        ack_now = rd_ack && eligible;
        ack_val = eligible ? cand_id_i : SPURIOUS_ID;
    end

    cif_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_mask(wr_mask),
        .wdata(bus_wdata_i), .en_q(en_q), .mask_q(mask_q),
        .ctrl_rd(ctrl_rd), .mask_rd(mask_rd)
    );

    cif_active #(.NUM_IDS(NUM_IDS)) u_act (
        .clk(clk), .rst_n(rst_n),
        .set_en(ack_now), .set_id(cand_id_i),
        .clr_en(wr_done), .clr_id(bus_wdata_i[ID_W-1:0]),
        .look_id(cand_id_i), .look_hit(busy)
    );

    cif_signal #(.NUM_IDS(NUM_IDS)) u_sig (
        .clk(clk), .rst_n(rst_n), .en(en_q), .mask(mask_q),
        .cand_valid(cand_valid_i), .cand_id(cand_id_i), .cand_prio(cand_prio_i),
        .cand_busy(busy), .ack_now(ack_now), .eligible(eligible), .irq_q(irq_o)
    );

    // Read-data mux; write-only and unused offsets read as zero.
    always_comb begin
        unique case (bus_addr_i)
            REG_CTRL: bus_rdata_o = ctrl_rd;
            REG_MASK: bus_rdata_o = mask_rd;
            REG_ACK:  bus_rdata_o = {{(DATA_W-ID_W){1'b0}}, ack_val};
            default:  bus_rdata_o = '0;
        endcase
    end

    // Acknowledge notification to the distributor.
    always_comb begin
        ack_valid_o = ack_now;
        ack_id_o    = cand_id_i;
    end
endmodule

// File: rtl/cif_checker.sv
// Module: protocol properties for cif_top, attached by bind.
// Assumes the internal names en_q and mask_q of the top module.
module cif_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       irq,
    input logic       en_q,
    input logic [7:0] mask_q,
    input logic [7:0] cand_prio,
    input logic       bus_en,
    input logic       bus_we,
    input logic [1:0] bus_addr,
    input logic       ack_valid,
    input logic [9:0] ack_id,
    input logic [31:0] rdata
);
    // R1: request only follows a cycle with signalling enabled
    a_r1_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(en_q));
    // R2: request only follows a candidate below the threshold
    a_r2_below_mask: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(cand_prio < mask_q));
    // R9: request is low in the cycle after any acknowledge read
    a_r9_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr == 2'd2) |=> !irq);
    // R6: pulse ID matches the returned read data
    a_r6_pulse_matches: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> (rdata[9:0] == ack_id && bus_en && !bus_we && bus_addr == 2'd2));
    // R10: acknowledged IDs are real IDs
    a_r10_real_id: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> ack_id <= 10'd1020);
endmodule

bind cif_top cif_checker u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq_o), .en_q(en_q), .mask_q(mask_q),
    .cand_prio(cand_prio_i), .bus_en(bus_en_i), .bus_we(bus_we_i),
    .bus_addr(bus_addr_i), .ack_valid(ack_valid_o), .ack_id(ack_id_o),
    .rdata(bus_rdata_o)
);

// File: tb/tb_cif_top.sv
module tb_cif_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cand_valid;
    logic [9:0]  cand_id;
    logic [7:0]  cand_prio;
    logic        bus_en, bus_we;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        irq, ack_valid;
    logic [9:0]  ack_id;

    int n_chk = 0;
    int n_bad = 0;

    cif_top dut (
        .clk(clk), .rst_n(rst_n), .cand_valid_i(cand_valid), .cand_id_i(cand_id),
        .cand_prio_i(cand_prio), .bus_en_i(bus_en), .bus_we_i(bus_we),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .irq_o(irq), .ack_valid_o(ack_valid), .ack_id_o(ack_id)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // vector: en, valid, id, prio, mask, expected irq
    typedef struct packed {
        logic       en;
        logic       valid;
        logic [9:0] id;
        logic [7:0] prio;
        logic [7:0] mask;
        logic       exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 1'b1, 10'd40,   8'hA0, 8'hF0, 1'b1},
        '{1'b0, 1'b1, 10'd40,   8'hA0, 8'hF0, 1'b0},
        '{1'b1, 1'b1, 10'd40,   8'hF0, 8'hF0, 1'b0},
        '{1'b1, 1'b1, 10'd5,    8'h00, 8'h01, 1'b1},
        '{1'b1, 1'b0, 10'd40,   8'h10, 8'hF0, 1'b0},
        '{1'b1, 1'b1, 10'd1021, 8'h10, 8'hF0, 1'b0},
        '{1'b1, 1'b1, 10'd20,   8'hEF, 8'hF0, 1'b1},
        '{1'b1, 1'b1, 10'd20,   8'h80, 8'h00, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    // Read in one cycle; returns data and pulse info sampled mid-cycle.
    task automatic bus_read(input logic [1:0] a, output logic [31:0] d,
                            output logic pv, output logic [9:0] pid);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata; pv = ack_valid; pid = ack_id;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        pv;
        logic [9:0]  pid;
        rst_n = 1'b0; cand_valid = 1'b0; cand_id = '0; cand_prio = '0;
        bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // Reset state
        check("R1 reset irq", {31'd0, irq}, 32'd0);
        bus_read(2'd0, d, pv, pid); check("R3 reset ctrl", d, 32'd0);
        bus_read(2'd1, d, pv, pid); check("R3 reset mask", d, 32'd0);

        // Vector table
        for (int v = 0; v < 8; v++) begin
            bus_write(2'd0, {31'd0, VECS[v].en});
            bus_write(2'd1, {24'd0, VECS[v].mask});
            cand_valid = VECS[v].valid; cand_id = VECS[v].id; cand_prio = VECS[v].prio;
            wait_cyc(2);
            check("R1/R2/R10 vector irq", {31'd0, irq}, {31'd0, VECS[v].exp});
        end

        // Readback with upper bits set in the write data
        bus_write(2'd0, 32'hFFFF_FFFF);
        bus_write(2'd1, 32'h1234_56F0);
        bus_read(2'd0, d, pv, pid); check("R3 ctrl readback", d, 32'd1);
        bus_read(2'd1, d, pv, pid); check("R3 mask readback", d, 32'hF0);

        // Disabled: acknowledge read is spurious
        cand_valid = 1'b1; cand_id = 10'd40; cand_prio = 8'h20;
        bus_write(2'd0, 32'd0);
        bus_read(2'd2, d, pv, pid);
        check("R1 disabled ack spurious", d, 32'd1023);
        check("R6 no pulse when spurious", {31'd0, pv}, 32'd0);

        // Enabled acknowledge
        bus_write(2'd0, 32'd1);
        wait_cyc(1);
        check("R2 irq up", {31'd0, irq}, 32'd1);
        bus_read(2'd2, d, pv, pid);
        check("R4 ack returns id", d, 32'd40);
        check("R6 pulse", {31'd0, pv}, 32'd1);
        check("R6 pulse id", {22'd0, pid}, 32'd40);
        check("R9 irq low after ack", {31'd0, irq}, 32'd0);
        wait_cyc(2);
        check("R7 active blocks", {31'd0, irq}, 32'd0);
        bus_read(2'd2, d, pv, pid);
        check("R5 spurious when only active pending", d, 32'd1023);

        // Completion for a non-active ID
        bus_write(2'd3, 32'd41);
        wait_cyc(2);
        check("R8 wrong completion ignored", {31'd0, irq}, 32'd0);

        // A new candidate appears while 40 is active
        cand_id = 10'd41; cand_prio = 8'h30;
        wait_cyc(2);
        check("R9 new candidate reasserts", {31'd0, irq}, 32'd1);
        bus_read(2'd2, d, pv, pid);
        check("R4 second ack", d, 32'd41);

        // Retire 40 and re-present it
        cand_id = 10'd40;
        bus_write(2'd3, 32'd40);
        wait_cyc(1);
        check("R7 presented again after completion", {31'd0, irq}, 32'd1);

        // Out-of-range ID never signalled
        cand_id = 10'd200;
        wait_cyc(2);
        check("R10 id beyond tracked range", {31'd0, irq}, 32'd0);
        bus_read(2'd2, d, pv, pid);
        check("R5 out-of-range gives spurious", d, 32'd1023);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule